// File: doc/BRIEF.md
# Dual-Mode Programmable Pulse Generator

Two 8-bit pulse generator channels share one register write port and one count-clock divider. Each channel counts down from a low-phase reload value while its output is low and from a high-phase reload value while its output is high. On underflow it switches phase, loads the count for the new phase and raises a one-cycle interrupt. The output period is therefore set by the sum of the two phase lengths and the duty by their ratio. The same boundary pulse lets a channel serve as a periodic event timer.

A mode field selects how the two channels work together. They can run as two independent generators. Channel 0 can act as a pure prescaler whose borrows clock channel 1, which gives a variable-frequency generator. The two counters can also be cascaded into a single 16-bit generator. Reload values written while a channel runs take effect at its next phase boundary, so software can retune the frequency and duty without glitches.

Top module: `dual_ppg`

## Requirements
- R1: After reset all reload registers are 0, the mode is independent, and `pulseOut` and `irq` are both 0.
- R2: Write map (`wrData` captured when `wrEn` is 1): address 0 holds the channel 0 low reload, 1 the channel 0 high reload, 2 the channel 1 low reload, 3 the channel 1 high reload, and 4 the mode in bits [1:0]. Mode 00 is independent, 01 is prescaler, 1x is 16-bit. A mode write returns both channels to their idle state for one cycle.
- R3: In independent mode each channel runs from its own `gateEn` bit. Its output is low for L+1 count ticks and high for H+1 count ticks, where L and H are that channel's low and high reloads.
- R4: A count tick occurs once every 2^`clkSel` clock cycles.
- R5: In prescaler mode `pulseOut[0]` stays low and channel 0 borrows once every L0+1 ticks. Channel 1 advances only on those borrows, so its low phase lasts (L1+1)(L0+1) ticks and its high phase lasts (H1+1)(L0+1) ticks.
- R6: In 16-bit mode the low reload is {L1,L0} and the high reload is {H1,H0}, with channel 0 as the low byte. `gateEn[0]` alone enables the generator. Both outputs carry the same waveform, low for the low reload +1 ticks and high for the high reload +1 ticks.
- R7: While a channel's gate is 0, its counter holds its low reload, its output is 0 one cycle later, and it raises no interrupt.
- R8: A reload written during a phase does not change that phase. It is used from the next boundary that loads that phase.
- R9: `irq[i]` is a one-cycle pulse in the cycle in which channel i's output changes at a phase boundary. In prescaler mode `irq[0]` pulses on every channel 0 borrow. In 16-bit mode only `irq[1]` pulses, and `irq[0]` stays 0.
- R10: Writes to addresses 5 to 7 change no register and no waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| clkSel | input | 2 | Count tick divider select (2^clkSel cycles) |
| gateEn | input | 2 | Per-channel run enable |
| pulseOut | output | 2 | Per-channel pulse outputs |
| irq | output | 2 | Per-channel phase-boundary / borrow pulses |

## Verification
On every cycle the assertions check the following. Outputs and interrupts fall silent one cycle after channel 0's gate drops. Channel 0's output stays quiet in prescaler mode. The two outputs agree in 16-bit mode, where `irq[0]` never fires. In independent mode every interrupt coincides with an output toggle. The bench scoreboard measures exact phase lengths, so only its scenarios can show the arithmetic of each mode: the divider scaling, the prescaler product, the 16-bit byte order, the deferral of a mid-phase reload write and the harmlessness of writes to unused addresses.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  localparam logic [1:0] MODE_IND = 2'b00;
  localparam logic [1:0] MODE_PRE = 2'b01;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_DEC     = 2'd1,
    ACT_LOADLOW = 2'd2,
    ACT_FLIP    = 2'd3
  } chAct_e;

  typedef struct packed {
    chAct_e     act1;
    chAct_e     act0;
    logic [1:0] nextPh;
    logic [1:0] irq;
  } ctlStrobe_t;

endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
  import ppg_pkg::*;
#(
  parameter int DIV_W     = 3,
  parameter int SEL_W     = 2,
  parameter int ADDR_W    = 3,
  parameter int MODE_ADDR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        modeQ,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic [1:0]        gateEn,
  input  logic [1:0]        zero,
  input  logic [1:0]        phase,
  output ctlStrobe_t        strobe
);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] tickMask;
  logic             tick;
  logic             restart;
  logic             borrow0;
  chAct_e           actVec [2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign tickMask = DIV_W'((1 << clkSel) - 1);
  assign tick     = ((divCnt & tickMask) == tickMask);
  assign restart  = wrEn && (wrAddr == ADDR_W'(MODE_ADDR));

  always_comb begin
    actVec[0]     = ACT_HOLD;
    actVec[1]     = ACT_HOLD;
    strobe.nextPh = 2'b00;
    strobe.irq    = 2'b00;
    borrow0       = 1'b0;
    if (restart) begin
      actVec[0] = ACT_LOADLOW;
      actVec[1] = ACT_LOADLOW;
    end else if (modeQ[1]) begin
      // cascaded 16-bit generator
      if (!gateEn[0]) begin
        actVec[0] = ACT_LOADLOW;
        actVec[1] = ACT_LOADLOW;
      end else if (tick) begin
        if (zero[0] && zero[1]) begin
          actVec[0]     = ACT_FLIP;
          actVec[1]     = ACT_FLIP;
          strobe.nextPh = {2{!phase[0]}};
          strobe.irq[1] = 1'b1;
        end else if (zero[0]) begin
          actVec[0] = ACT_DEC;
          actVec[1] = ACT_DEC;
        end else begin
          actVec[0] = ACT_DEC;
        end
      end
    end else if (modeQ == MODE_PRE) begin
      // channel 0 divides ticks, channel 1 counts its borrows
      if (!gateEn[0]) begin
        actVec[0] = ACT_LOADLOW;
      end else if (tick) begin
        if (zero[0]) begin
          actVec[0]     = ACT_LOADLOW;
          strobe.irq[0] = 1'b1;
          borrow0       = 1'b1;
        end else begin
          actVec[0] = ACT_DEC;
        end
      end
      if (!gateEn[1]) begin
        actVec[1] = ACT_LOADLOW;
      end else if (borrow0) begin
        if (zero[1]) begin
          actVec[1]        = ACT_FLIP;
          strobe.nextPh[1] = !phase[1];
          strobe.irq[1]    = 1'b1;
        end else begin
          actVec[1] = ACT_DEC;
        end
      end
    end else begin
      // two independent generators
      for (int i = 0; i < 2; i++) begin
        if (!gateEn[i]) begin
          actVec[i] = ACT_LOADLOW;
        end else if (tick) begin
          if (zero[i]) begin
            actVec[i]        = ACT_FLIP;
            strobe.nextPh[i] = !phase[i];
            strobe.irq[i]    = 1'b1;
          end else begin
            actVec[i] = ACT_DEC;
          end
        end
      end
    end
    strobe.act0 = actVec[0];
    strobe.act1 = actVec[1];
  end

endmodule

// File: rtl/ppg_datapath.sv
module ppg_datapath
  import ppg_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 3,
  parameter int MODE_ADDR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  ctlStrobe_t        strobe,
  output logic [1:0]        modeQ,
  output logic [1:0]        zero,
  output logic [1:0]        phase,
  output logic [1:0]        irqQ
);

  localparam int NUM_CH = 2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_IND;
    else if (wrEn && wrAddr == ADDR_W'(MODE_ADDR)) modeQ <= wrData[1:0];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] loReg;
    logic [CNT_W-1:0] hiReg;
    logic [CNT_W-1:0] cnt;
    logic             phBit;
    logic             irqBit;
    chAct_e           act;

    assign act = (ch == 0) ? strobe.act0 : strobe.act1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loReg <= '0;
        hiReg <= '0;
      end else if (wrEn) begin
        if (wrAddr == ADDR_W'(2 * ch))     loReg <= wrData;
        if (wrAddr == ADDR_W'(2 * ch + 1)) hiReg <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt    <= '0;
        phBit  <= 1'b0;
        irqBit <= 1'b0;
      end else begin
        irqBit <= strobe.irq[ch];
        unique case (act)
          ACT_DEC: cnt <= cnt - 1'b1;
          ACT_LOADLOW: begin
            cnt   <= loReg;
            phBit <= 1'b0;
          end
          ACT_FLIP: begin
            cnt   <= strobe.nextPh[ch] ? hiReg : loReg;
            phBit <= strobe.nextPh[ch];
          end
          default: cnt <= cnt;
        endcase
      end
    end

    assign zero[ch]  = (cnt == '0);
    assign phase[ch] = phBit;
    assign irqQ[ch]  = irqBit;
  end

endmodule

// File: rtl/dual_ppg.sv
module dual_ppg
  import ppg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [1:0] clkSel,
  input  logic [1:0] gateEn,
  output logic [1:0] pulseOut,
  output logic [1:0] irq
);

  localparam int CNT_W     = 8;
  localparam int ADDR_W    = 3;
  localparam int SEL_W     = 2;
  localparam int DIV_W     = (1 << SEL_W) - 1;
  localparam int MODE_ADDR = 4;

  ctlStrobe_t strobe;
  logic [1:0] curMode;
  logic [1:0] zero;

  ppg_ctrl #(
    .DIV_W(DIV_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .modeQ(curMode),
    .clkSel(clkSel), .gateEn(gateEn), .zero(zero), .phase(pulseOut),
    .strobe(strobe)
  );

  ppg_datapath #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)
  ) i_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .modeQ(curMode), .zero(zero), .phase(pulseOut),
    .irqQ(irq)
  );

endmodule

// File: rtl/ppg_checker.sv
module ppg_checker
  import ppg_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] gateEn,
  input logic [1:0] pulseOut,
  input logic [1:0] irq,
  input logic [1:0] curMode
);

  AST_GATE_LOW_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn[0] |=> !pulseOut[0]); // R7

  AST_GATE_LOW_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn[0] |=> !irq[0]); // R7

  AST_PRE_CH0_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_PRE && $past(curMode) == MODE_PRE) |-> !pulseOut[0]); // R5

  AST_WIDE_OUT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (curMode[1] && $past(curMode[1])) |-> (pulseOut[0] == pulseOut[1])); // R6

  AST_WIDE_IRQ0_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    curMode[1] |-> !irq[0]); // R9

  AST_IND_IRQ_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_IND && irq[0]) |-> (pulseOut[0] != $past(pulseOut[0]))); // R9

endmodule

bind dual_ppg ppg_checker i_chk (
  .clk(clk), .rstN(rstN), .gateEn(gateEn), .pulseOut(pulseOut),
  .irq(irq), .curMode(curMode)
);

// File: tb/test_dual_ppg.sv
module test_dual_ppg;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] clkSel = '0;
  logic [1:0] gateEn = '0;
  logic [1:0] pulseOut;
  logic [1:0] irq;

  dual_ppg i_dual_ppg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clkSel(clkSel), .gateEn(gateEn), .pulseOut(pulseOut), .irq(irq)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    nChecks = 0, nFail = 0;
  int    monChecks = 0, monFails = 0;
  int    expQ[$];
  string reqQ[$];
  logic  monOn = 1'b0;
  int    monSel = 0;

  // monitor: measures intervals between output edges after the first rise
  logic prevOn = 1'b0, prevOut = 1'b0, armed = 1'b0, curOut;
  int   lastCyc = 0;
  always @(negedge clk) begin
    if (monOn && !prevOn) armed = 1'b0;
    prevOn = monOn;
    if (monOn) begin
      curOut = pulseOut[monSel];
      if (curOut != prevOut) begin
        if (armed) begin
          if (expQ.size() > 0) begin
            int    interval;
            int    expv;
            string rq;
            interval = cyc - lastCyc;
            expv = expQ.pop_front();
            rq = reqQ.pop_front();
            monChecks++;
            if (interval != expv) begin
              monFails++;
              $display("FAIL %s phase length: actual %0d expected %0d", rq, interval, expv);
            end
          end
          lastCyc = cyc;
        end else if (curOut) begin
          armed = 1'b1;
          lastCyc = cyc;
        end
      end
      prevOut = curOut;
    end else begin
      prevOut = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expect4(input int a, input int b, input int c, input int d, input string req);
    expQ.push_back(a); reqQ.push_back(req);
    expQ.push_back(b); reqQ.push_back(req);
    expQ.push_back(c); reqQ.push_back(req);
    expQ.push_back(d); reqQ.push_back(req);
  endtask

  task automatic startRun(input int sel, input logic [1:0] gates);
    @(negedge clk);
    monSel = sel; monOn = 1'b1;
    @(negedge clk);
    gateEn = gates;
  endtask

  task automatic finishRun(input int limit, input string req);
    int waited = 0;
    while (expQ.size() > 0 && waited < limit) begin
      @(negedge clk);
      waited++;
    end
    if (expQ.size() > 0) begin
      check(1'b0, req, expQ.size(), 0);
      expQ.delete(); reqQ.delete();
    end
    @(negedge clk);
    gateEn = 2'b00; monOn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
    $display("  == %0d vectors applied, %0d miscompares ==",
             nChecks + monChecks + 1, nFail + monFails + 1);
    $finish;
  end

  initial begin
    int cnt;
    logic seen;
    repeat (3) @(negedge clk);
    check(pulseOut == 2'b00, "R1 outputs in reset", int'(pulseOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(pulseOut == 2'b00 && irq == 2'b00, "R1 outputs after reset", int'({pulseOut, irq}), 0);

    // R3 / R2: independent channel 0, L=3 H=5
    wr(0, 3); wr(1, 5);
    expect4(6, 4, 6, 4, "R3 ch0 independent");
    startRun(0, 2'b01);
    finishRun(200, "R3 ch0 timeout");
    // R7: gate low holds output low
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pulseOut[0] || irq[0]) seen = 1'b1;
    end
    check(!seen, "R7 gate low output and irq", int'(seen), 0);

    // R3 boundary: channel 1 with zero reloads, channel 0 gated off
    wr(2, 0); wr(3, 0);
    expect4(1, 1, 1, 1, "R3 ch1 zero reloads");
    startRun(1, 2'b10);
    check(pulseOut[0] == 1'b0, "R3 ch0 unaffected by ch1 gate", int'(pulseOut[0]), 0);
    finishRun(100, "R3 ch1 timeout");

    // R4: divide by 4, L=1 H=2
    clkSel = 2'd2;
    wr(0, 1); wr(1, 2);
    expect4(12, 8, 12, 8, "R4 clkSel=2");
    startRun(0, 2'b01);
    finishRun(300, "R4 timeout");
    clkSel = 2'd0;

    // R5: prescaler L0=2, ch1 L1=1 H1=3
    wr(0, 2); wr(1, 9); wr(2, 1); wr(3, 3); wr(4, 1);
    expect4(12, 6, 12, 6, "R5 prescaler ch1");
    startRun(1, 2'b11);
    seen = 1'b0;
    while (expQ.size() > 0) begin
      @(negedge clk);
      if (pulseOut[0]) seen = 1'b1;
    end
    check(!seen, "R5 ch0 output quiet in prescaler mode", int'(seen), 0);
    finishRun(300, "R5 timeout");

    // R6: 16-bit, low=0x0102, high=0x0003
    wr(0, 2); wr(2, 1); wr(1, 3); wr(3, 0); wr(4, 2);
    expect4(4, 259, 4, 259, "R6 16-bit byte order");
    startRun(1, 2'b01);
    seen = 1'b0; cnt = 0;
    while (expQ.size() > 0) begin
      @(negedge clk);
      if (pulseOut[0] != pulseOut[1]) seen = 1'b1;
      if (irq[0]) cnt++;
    end
    check(!seen, "R6 outputs identical in 16-bit mode", int'(seen), 0);
    check(cnt == 0, "R9 irq0 quiet in 16-bit mode", cnt, 0);
    finishRun(2000, "R6 timeout");

    // R8: high reload rewritten mid high phase
    wr(4, 0); wr(0, 3); wr(1, 5);
    expect4(6, 4, 2, 4, "R8 deferred reload");
    startRun(0, 2'b01);
    @(posedge pulseOut[0]);
    wr(1, 1);
    finishRun(200, "R8 timeout");

    // R10: writes to unused addresses change nothing
    wr(1, 5); wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
    expect4(6, 4, 6, 4, "R10 unused addresses");
    startRun(0, 2'b01);
    finishRun(200, "R10 timeout");

    // R9: event rate with L=1 H=1, a boundary every 2 cycles
    wr(0, 1); wr(1, 1);
    @(negedge clk); gateEn = 2'b01;
    repeat (10) @(negedge clk);
    cnt = 0; seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (irq[0]) cnt++;
      if (irq[1]) seen = 1'b1;
    end
    check(cnt == 20, "R9 irq0 pulse count", cnt, 20);
    check(!seen, "R9 irq1 quiet with gate low", int'(seen), 0);
    gateEn = 2'b00;
    repeat (2) @(negedge clk);
    check(pulseOut == 2'b00, "R7 idle after run", int'(pulseOut), 0);

    $display("  == %0d vectors applied, %0d miscompares ==",
             nChecks + monChecks, nFail + monFails);
    $finish;
  end

endmodule